// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers active-high interrupt levels from up to 32 sources and sends each one to one of two processor request lines. A source line counts as asserted when its input pin is high or when software has set its bit in a software-trigger register. A raw view shows every asserted source before masking. A per-source enable mask decides which sources go further. A per-source route register then sends each enabled source to the fast request line or to the normal request line. The fast line is a plain OR of its sources and has no priority logic.

Normal requests go through sixteen vector slots. Each slot holds a handler address and can be bound to one source number. Slot 0 has the highest priority and slot 15 the lowest. An enabled normal source that no enabled slot claims is served through one shared default handler address, which ranks below every slot.

Reading the vector register returns the handler address of the current winner and marks that level as in service. While a level is in service, that level and every level below it are held off, and a higher level can still preempt. Writing the vector register ends service of the most recently entered level and restores the level that was in service before it. All registers sit on a simple single-cycle register bus. Reads are combinational.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source is asserted when its input line is high or its bit is set in the software-trigger register. Offset 0x06 sets bits when written with 1s and reads back the register. Offset 0x07 clears bits when written with 1s. Offset 0x00 reads the OR of input lines and software bits. A software bit drives the outputs exactly like a high input line.
- R2: The enable mask is set by writing 1s to offset 0x04 and cleared by writing 1s to offset 0x05. It reads back at 0x04. A source whose enable bit is 0 never reaches either output or either routed status register.
- R3: Clearing an enable bit does not clear the source's raw status. If the source is still asserted when it is enabled again, the output rises one clock edge after the edge that wrote the enable.
- R4: The route register at offset 0x03 sends an enabled source to the fast path when its bit is 1 and to the normal path when its bit is 0. Offset 0x01 reads the enabled normal-path sources and offset 0x02 reads the enabled fast-path sources.
- R5: fiq_out goes high one clock edge after any enabled fast-path source is asserted. It is not affected by the vector slots or by the in-service state.
- R6: Slot k (k = 0..15) keeps its handler address at offset 0x10+k. Its control register is at offset 0x20+k: bit 5 is the slot enable and bits 4:0 are the source number. A slot whose enable bit is clear never claims or matches a source.
- R7: An enabled normal-path source that no enabled slot claims is default-vectored. All such sources share the default address register at offset 0x09.
- R8: A read of the vector register at offset 0x08 returns the handler address of the lowest-numbered eligible slot. If no slot is eligible it returns the default address, whether or not a default-vectored request is pending. A read with nothing eligible changes no state.
- R9: irq_out goes high one clock edge after any slot or default request becomes eligible, and goes low one edge after none is eligible.
- R10: A read of the vector register that finds a winner puts the winner's level in service. From then on that level and all lower-priority levels, including the default level, are not eligible. Higher-priority slots stay eligible and can preempt.
- R11: A write to the vector register ends service of the highest-priority level in service and restores the level before it. With nothing in service the write has no effect.
- R12: After reset all registers read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_SRC | Active-high source levels |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational |
| irq_out | output | 1 | Normal (vectored) request, active high |
| fiq_out | output | 1 | Fast request, active high |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the access. Both request outputs are registered. A change on a source line appears on an output one clock edge later. A register write, whether to the enable or route register or an end of service on the vector register, takes effect at the edge that performs the write and appears on an output at the following edge. The bench drives all stimulus at the falling edge and waits for exactly that number of rising edges before it samples. In one case it also samples one edge early to confirm that the output has not yet moved.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

   // register word offsets (6-bit map)
   localparam logic [5:0] OFS_RAW       = 6'h00;
   localparam logic [5:0] OFS_IRQ_STAT  = 6'h01;
   localparam logic [5:0] OFS_FIQ_STAT  = 6'h02;
   localparam logic [5:0] OFS_ROUTE     = 6'h03;
   localparam logic [5:0] OFS_EN_SET    = 6'h04;
   localparam logic [5:0] OFS_EN_CLR    = 6'h05;
   localparam logic [5:0] OFS_SW_SET    = 6'h06;
   localparam logic [5:0] OFS_SW_CLR    = 6'h07;
   localparam logic [5:0] OFS_VECT      = 6'h08;
   localparam logic [5:0] OFS_DEF_ADDR  = 6'h09;
   localparam logic [5:0] OFS_SLOT_ADDR = 6'h10;
   localparam logic [5:0] OFS_SLOT_CTRL = 6'h20;

   localparam int MAP_ADDR_W  = 6;
   localparam int SRC_FIELD_W = 5;
   localparam int SLOT_EN_BIT = 5;
   localparam int MAX_SRC     = 1 << SRC_FIELD_W;

   typedef struct packed {
      logic                   en;
      logic [SRC_FIELD_W-1:0] src;
   } slot_cfg_t;

endpackage

// File: rtl/irq_vec_route.sv
module irq_vec_route #(
   parameter int NUM_SRC = 32
) (
   input  logic [NUM_SRC-1:0] lines,
   input  logic [NUM_SRC-1:0] soft_q,
   input  logic [NUM_SRC-1:0] en_q,
   input  logic [NUM_SRC-1:0] route_q,
   output logic [NUM_SRC-1:0] raw,
   output logic [NUM_SRC-1:0] irq_req,
   output logic [NUM_SRC-1:0] fiq_req
);
   logic [NUM_SRC-1:0] masked;

   assign raw     = lines | soft_q;
   assign masked  = raw & en_q;
   assign fiq_req = masked & route_q;
   assign irq_req = masked & ~route_q;
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
   import irq_vector_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_SLOT = 16,
   parameter int VEC_W    = 32,
   parameter int LVL_W    = 5
) (
   input  logic [NUM_SRC-1:0] irq_req,
   input  slot_cfg_t          slot_cfg  [NUM_SLOT],
   input  logic [VEC_W-1:0]   slot_addr [NUM_SLOT],
   input  logic [VEC_W-1:0]   def_addr,
   input  logic [LVL_W-1:0]   ceiling,
   output logic               any_elig,
   output logic [LVL_W-1:0]   win_level,
   output logic [VEC_W-1:0]   win_addr
);
   localparam logic [LVL_W-1:0] DEF_LVL  = LVL_W'(NUM_SLOT);
   localparam logic [LVL_W-1:0] NONE_LVL = LVL_W'(NUM_SLOT + 1);

   logic [MAX_SRC-1:0]  req_ext;
   logic [MAX_SRC-1:0]  claimed;
   logic [NUM_SLOT-1:0] hit;
   logic [NUM_SLOT-1:0] elig;
   logic                unclaimed_any;
   logic                def_elig;

   assign req_ext = MAX_SRC'(irq_req);

   always_comb begin
      claimed = '0;
      for (int k = 0; k < NUM_SLOT; k++) begin
         if (slot_cfg[k].en) claimed[slot_cfg[k].src] = 1'b1;
      end
   end

   assign unclaimed_any = |(req_ext & ~claimed);

   for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
      assign hit[k]  = slot_cfg[k].en & req_ext[slot_cfg[k].src];
      assign elig[k] = hit[k] & (LVL_W'(k) < ceiling);
   end

   assign def_elig = unclaimed_any & (DEF_LVL < ceiling);
   assign any_elig = (|elig) | def_elig;

   always_comb begin
      win_level = def_elig ? DEF_LVL : NONE_LVL;
      win_addr  = def_addr;
      for (int k = NUM_SLOT - 1; k >= 0; k--) begin
         if (elig[k]) begin
            win_level = LVL_W'(k);
            win_addr  = slot_addr[k];
         end
      end
   end
endmodule

// File: rtl/irq_vec_nest.sv
module irq_vec_nest #(
   parameter int NUM_LVL = 17,
   parameter int LVL_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LVL_W-1:0] push_level,
   input  logic             pop,
   output logic [LVL_W-1:0] ceiling
);
   logic [NUM_LVL-1:0] busy_q;
   logic [NUM_LVL-1:0] top_bit;
   logic [NUM_LVL-1:0] push_vec;

   // nested levels are always higher priority, so the newest is the lowest set bit
   assign top_bit  = busy_q & (~busy_q + NUM_LVL'(1));
   assign push_vec = NUM_LVL'(1) << push_level;

   always_comb begin
      ceiling = LVL_W'(NUM_LVL);
      for (int i = NUM_LVL - 1; i >= 0; i--) begin
         if (busy_q[i]) ceiling = LVL_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_q <= '0;
      else if (push) busy_q <= busy_q | push_vec;
      else if (pop)  busy_q <= busy_q & ~top_bit;
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vector_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_SLOT = 16,
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic               reg_sel,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_out,
   output logic               fiq_out
);
   localparam int NUM_LVL = NUM_SLOT + 1;
   localparam int LVL_W   = $clog2(NUM_SLOT + 2);

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (NUM_SLOT < 1 || NUM_SLOT > 16) begin : g_bad_slot
      $error("NUM_SLOT out of range");
   end
   if (ADDR_W < MAP_ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end
   if (DATA_W < NUM_SRC || DATA_W <= SLOT_EN_BIT) begin : g_bad_data
      $error("DATA_W too narrow");
   end

   logic [NUM_SRC-1:0] en_q, route_q, soft_q;
   logic [DATA_W-1:0]  def_addr_q;
   logic [DATA_W-1:0]  slot_addr_q [NUM_SLOT];
   slot_cfg_t          slot_cfg_q  [NUM_SLOT];

   logic [NUM_SRC-1:0] raw, irq_req, fiq_req;
   logic               any_elig;
   logic [LVL_W-1:0]   win_level, ceiling;
   logic [DATA_W-1:0]  win_addr;

   logic               wr_en, rd_en, vect_rd, ack, eoi, soft_clr_wr;
   logic [NUM_SRC-1:0] wbits;

   assign wr_en       = reg_sel & reg_wr;
   assign rd_en       = reg_sel & ~reg_wr;
   assign vect_rd     = rd_en & (reg_addr == ADDR_W'(OFS_VECT));
   assign ack         = vect_rd & any_elig;
   assign eoi         = wr_en & (reg_addr == ADDR_W'(OFS_VECT));
   assign soft_clr_wr = wr_en & (reg_addr == ADDR_W'(OFS_SW_CLR));
   assign wbits       = reg_wdata[NUM_SRC-1:0];

   irq_vec_route #(.NUM_SRC(NUM_SRC)) i_route (
      .lines   (irq_lines),
      .soft_q  (soft_q),
      .en_q    (en_q),
      .route_q (route_q),
      .raw     (raw),
      .irq_req (irq_req),
      .fiq_req (fiq_req)
   );

   irq_vec_arbiter #(
      .NUM_SRC  (NUM_SRC),
      .NUM_SLOT (NUM_SLOT),
      .VEC_W    (DATA_W),
      .LVL_W    (LVL_W)
   ) i_arb (
      .irq_req   (irq_req),
      .slot_cfg  (slot_cfg_q),
      .slot_addr (slot_addr_q),
      .def_addr  (def_addr_q),
      .ceiling   (ceiling),
      .any_elig  (any_elig),
      .win_level (win_level),
      .win_addr  (win_addr)
   );

   irq_vec_nest #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) i_nest (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (ack),
      .push_level (win_level),
      .pop        (eoi),
      .ceiling    (ceiling)
   );

   // mask, route and software-trigger registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         route_q    <= '0;
         soft_q     <= '0;
         def_addr_q <= '0;
      end else if (wr_en) begin
         if (reg_addr == ADDR_W'(OFS_ROUTE))    route_q    <= wbits;
         if (reg_addr == ADDR_W'(OFS_EN_SET))   en_q       <= en_q | wbits;
         if (reg_addr == ADDR_W'(OFS_EN_CLR))   en_q       <= en_q & ~wbits;
         if (reg_addr == ADDR_W'(OFS_SW_SET))   soft_q     <= soft_q | wbits;
         if (reg_addr == ADDR_W'(OFS_SW_CLR))   soft_q     <= soft_q & ~wbits;
         if (reg_addr == ADDR_W'(OFS_DEF_ADDR)) def_addr_q <= reg_wdata;
      end
   end

   // per-slot address and control registers
   for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_addr_q[k] <= '0;
            slot_cfg_q[k]  <= '0;
         end else if (wr_en) begin
            if (reg_addr == ADDR_W'(OFS_SLOT_ADDR) + ADDR_W'(k))
               slot_addr_q[k] <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_SLOT_CTRL) + ADDR_W'(k)) begin
               slot_cfg_q[k].en  <= reg_wdata[SLOT_EN_BIT];
               slot_cfg_q[k].src <= reg_wdata[SRC_FIELD_W-1:0];
            end
         end
      end
   end

   // combinational read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_RAW))      reg_rdata = DATA_W'(raw);
      if (reg_addr == ADDR_W'(OFS_IRQ_STAT)) reg_rdata = DATA_W'(irq_req);
      if (reg_addr == ADDR_W'(OFS_FIQ_STAT)) reg_rdata = DATA_W'(fiq_req);
      if (reg_addr == ADDR_W'(OFS_ROUTE))    reg_rdata = DATA_W'(route_q);
      if (reg_addr == ADDR_W'(OFS_EN_SET))   reg_rdata = DATA_W'(en_q);
      if (reg_addr == ADDR_W'(OFS_SW_SET))   reg_rdata = DATA_W'(soft_q);
      if (reg_addr == ADDR_W'(OFS_VECT))     reg_rdata = win_addr;
      if (reg_addr == ADDR_W'(OFS_DEF_ADDR)) reg_rdata = def_addr_q;
      for (int k = 0; k < NUM_SLOT; k++) begin
         if (reg_addr == ADDR_W'(OFS_SLOT_ADDR) + ADDR_W'(k))
            reg_rdata = slot_addr_q[k];
         if (reg_addr == ADDR_W'(OFS_SLOT_CTRL) + ADDR_W'(k))
            reg_rdata = DATA_W'({slot_cfg_q[k].en, slot_cfg_q[k].src});
      end
   end

   // output stage variant
   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_out <= 1'b0;
            fiq_out <= 1'b0;
         end else begin
            irq_out <= any_elig;
            fiq_out <= |fiq_req;
         end
      end
   end else begin : g_out_comb
      assign irq_out = any_elig;
      assign fiq_out = |fiq_req;
   end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int NUM_SRC = 32,
   parameter int NUM_LVL = 17,
   parameter int LVL_W   = 5,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_out,
   input logic               fiq_out,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] fiq_req,
   input logic [NUM_SRC-1:0] soft_q,
   input logic               any_elig,
   input logic [LVL_W-1:0]   win_level,
   input logic [LVL_W-1:0]   ceiling,
   input logic               ack,
   input logic               eoi,
   input logic               soft_clr_wr,
   input logic [DATA_W-1:0]  reg_wdata
);
   // R1
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr_wr |=> ((soft_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

   // R10
   ack_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (ceiling == $past(win_level)));

   // R11
   eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && ceiling == LVL_W'(NUM_LVL)) |=> (ceiling == LVL_W'(NUM_LVL)));

   if (REG_OUT) begin : g_out_chk
      // R2
      disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q == '0) |=> (!irq_out && !fiq_out));

      // R5
      fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|fiq_req) |=> fiq_out);

      // R9
      irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         any_elig |=> irq_out);

      // R9
      irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !any_elig |=> !irq_out);
   end
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .NUM_LVL (NUM_LVL),
   .LVL_W   (LVL_W),
   .DATA_W  (DATA_W),
   .REG_OUT (REG_OUT)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_out     (irq_out),
   .fiq_out     (fiq_out),
   .en_q        (en_q),
   .fiq_req     (fiq_req),
   .soft_q      (soft_q),
   .any_elig    (any_elig),
   .win_level   (win_level),
   .ceiling     (ceiling),
   .ack         (ack),
   .eoi         (eoi),
   .soft_clr_wr (soft_clr_wr),
   .reg_wdata   (reg_wdata)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/100ps
module test_irq_vector_ctrl;

   localparam logic [5:0] A_RAW = 6'h00, A_IRQS = 6'h01, A_FIQS = 6'h02, A_ROUTE = 6'h03;
   localparam logic [5:0] A_ENS = 6'h04, A_ENC = 6'h05, A_SWS = 6'h06, A_SWC = 6'h07;
   localparam logic [5:0] A_VECT = 6'h08, A_DEF = 6'h09, A_SADDR = 6'h10, A_SCTRL = 6'h20;

   typedef struct packed {
      logic [31:0] src, en, route, irq_st, fiq_st;
      logic        irq, fiq;
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{32'h0000_00F0, 32'h0000_0030, 32'h0000_0010, 32'h0000_0020, 32'h0000_0010, 1'b1, 1'b1},
      '{32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b1},
      '{32'h0F00_0000, 32'h00FF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      '{32'h0000_FF00, 32'h0000_0F00, 32'h0000_0F00, 32'h0000_0000, 32'h0000_0F00, 1'b0, 1'b1},
      '{32'h1234_5678, 32'hFF00_00FF, 32'h0F00_000F, 32'h1000_0070, 32'h0200_0008, 1'b1, 1'b1},
      '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out, fiq_out;

   int n_chk = 0, n_bad = 0;
   logic [31:0] d;

   always #2.5 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .fiq_out(fiq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] v);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(posedge clk); @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #1 v = reg_rdata;
      @(posedge clk); @(negedge clk);
      reg_sel = 1'b0;
   endtask

   task automatic settle();
      @(posedge clk); @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R12 reset state
      chk("R12 irq_out", 32'(irq_out), 0);
      chk("R12 fiq_out", 32'(fiq_out), 0);
      rd(A_RAW, d);   chk("R12 raw", d, 0);
      rd(A_ENS, d);   chk("R12 enable", d, 0);
      rd(A_ROUTE, d); chk("R12 route", d, 0);
      rd(A_SWS, d);   chk("R12 soft", d, 0);
      rd(A_DEF, d);   chk("R12 default", d, 0);
      rd(A_SCTRL + 6'd3, d); chk("R12 slot ctrl", d, 0);

      // table: masking and routing (R2 R4 R5 R9)
      foreach (TBL[i]) begin
         irq_lines = TBL[i].src;
         wr(A_ENC, 32'hFFFF_FFFF);
         wr(A_ENS, TBL[i].en);
         wr(A_ROUTE, TBL[i].route);
         settle();
         rd(A_IRQS, d); chk($sformatf("R4 irq status vec %0d", i), d, TBL[i].irq_st);
         rd(A_FIQS, d); chk($sformatf("R4 fiq status vec %0d", i), d, TBL[i].fiq_st);
         chk($sformatf("R9 irq_out vec %0d", i), 32'(irq_out), 32'(TBL[i].irq));
         chk($sformatf("R5 fiq_out vec %0d", i), 32'(fiq_out), 32'(TBL[i].fiq));
      end

      // R1 software trigger
      irq_lines = '0;
      wr(A_ENC, 32'hFFFF_FFFF);
      wr(A_ROUTE, 0);
      wr(A_SWS, 32'h5);
      settle();
      rd(A_RAW, d); chk("R1 raw after soft set", d, 32'h5);
      chk("R2 disabled soft stays quiet", 32'(irq_out), 0);
      wr(A_ENS, 32'h1);
      settle();
      chk("R1 soft bit drives irq_out", 32'(irq_out), 1);
      rd(A_IRQS, d); chk("R1 soft irq status", d, 32'h1);
      wr(A_SWC, 32'h1);
      settle();
      rd(A_RAW, d); chk("R1 raw after soft clear", d, 32'h4);
      chk("R1 irq_out after soft clear", 32'(irq_out), 0);
      wr(A_SWC, 32'h4);
      wr(A_ENC, 32'hFFFF_FFFF);

      // R3 pending kept while disabled, enable latency
      irq_lines = 32'h8;
      settle();
      rd(A_RAW, d); chk("R3 raw while disabled", d, 32'h8);
      chk("R2 disabled line quiet", 32'(irq_out), 0);
      wr(A_ENS, 32'h8);
      chk("R3 not yet at write edge", 32'(irq_out), 0);
      settle();
      chk("R3 irq_out next edge after enable", 32'(irq_out), 1);
      wr(A_ENC, 32'h8);
      settle();
      chk("R3 irq_out after disable", 32'(irq_out), 0);
      rd(A_RAW, d); chk("R3 raw kept after disable", d, 32'h8);
      irq_lines = '0;

      // vector slot setup (R6)
      wr(A_DEF, 32'h0000_D000);
      for (int k = 0; k < 16; k++) wr(A_SADDR + 6'(k), 32'h1000 + 32'(k) * 32'h10);
      wr(A_SCTRL + 6'd2, 32'h27);
      wr(A_SCTRL + 6'd5, 32'h29);
      wr(A_SCTRL + 6'd9, 32'h0C);
      rd(A_SCTRL + 6'd2, d); chk("R6 slot ctrl readback", d, 32'h27);
      rd(A_SADDR + 6'd5, d); chk("R6 slot addr readback", d, 32'h1050);
      wr(A_ENS, 32'hFFFF_FFFF);

      // R7 default vector, R6 disabled slot does not claim
      irq_lines = 32'h1 << 12;
      settle();
      chk("R7 default request raises irq_out", 32'(irq_out), 1);
      rd(A_VECT, d); chk("R7 default address", d, 32'hD000);
      settle();
      chk("R10 default in service masks default", 32'(irq_out), 0);
      wr(A_VECT, 0);
      settle();
      chk("R11 end of service re-arms default", 32'(irq_out), 1);

      // R8 slot beats default, R10 nesting, R11 restore
      irq_lines = (32'h1 << 9) | (32'h1 << 12);
      settle();
      rd(A_VECT, d); chk("R8 slot 5 beats default", d, 32'h1050);
      settle();
      chk("R10 slot 5 in service masks lower", 32'(irq_out), 0);
      irq_lines = irq_lines | (32'h1 << 7);
      settle();
      chk("R10 slot 2 preempts", 32'(irq_out), 1);
      rd(A_VECT, d); chk("R8 slot 2 wins", d, 32'h1020);
      irq_lines = (32'h1 << 9) | (32'h1 << 12);
      settle();
      chk("R10 two levels in service", 32'(irq_out), 0);
      wr(A_VECT, 0);
      settle();
      chk("R11 slot 5 still in service", 32'(irq_out), 0);

      // R5 fast path ignores in-service state
      wr(A_ROUTE, 32'h1 << 20);
      irq_lines = irq_lines | (32'h1 << 20);
      settle();
      chk("R5 fiq_out with level in service", 32'(fiq_out), 1);
      rd(A_FIQS, d); chk("R4 fiq status source 20", d, 32'h1 << 20);
      irq_lines = irq_lines & ~(32'h1 << 20);
      wr(A_ROUTE, 0);
      settle();
      chk("R5 fiq_out drops", 32'(fiq_out), 0);

      wr(A_VECT, 0);
      settle();
      chk("R11 restore to idle re-arms slot 5", 32'(irq_out), 1);
      rd(A_VECT, d); chk("R8 slot 5 again", d, 32'h1050);
      wr(A_VECT, 0);
      wr(A_VECT, 0);

      // R8 empty read has no effect
      irq_lines = '0;
      settle();
      chk("R9 irq_out low with nothing eligible", 32'(irq_out), 0);
      rd(A_VECT, d); chk("R8 empty read returns default", d, 32'hD000);
      irq_lines = 32'h1 << 9;
      settle();
      chk("R8 empty read left no mask", 32'(irq_out), 1);
      rd(A_VECT, d); chk("R8 slot 5 after empty read", d, 32'h1050);
      wr(A_VECT, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule